// File: doc/BRIEF.md
# Mode-Dependent Shared Data-Bus GPIO Port

This block drives a bank of eight bidirectional pins. The pins serve one of two purposes. In one they are general-purpose I/O, with the direction, output level and input pull-up set for each pin on its own. In the other they carry the low byte of an external data bus. The purpose follows from a 3-bit operating-mode input and a bus-width input. Modes 3 and 7 are single-chip modes and always give general I/O. Every other mode value is an expanded mode: it gives general I/O with an 8-bit bus and data-bus operation with a 16-bit bus.

Software reaches three registers through a small write/read port: direction, output data and pull-up control. Reads return the register contents, except for the data address, which mixes the driven values and the sampled pin levels. The block has four reset and standby inputs. Power-on reset clears every register. Manual reset clears direction and output data but keeps the pull-up settings. Hardware standby clears the pull-up settings. Software standby keeps every register.

Top module: `dual_use_port`

## Requirements
- R1: In general-I/O operation, padOe[i] equals direction bit i (1 = output), and padOut equals the output data register.
- R2: General-I/O operation is selected when mode is 3 or 7 at any bus width, or when busWide is 0 in any other mode.
- R3: Data-bus operation is selected when mode is not 3 or 7 and busWide is 1. In it, padOut equals busWrData and every padOe bit equals busDriveReq, whatever the direction register holds.
- R4: padPullUp[i] is 1 only in general-I/O operation with direction bit i at 0 and pull-up bit i at 1. A pin that is driven, or used for the data bus, never has its pull-up on.
- R5: Register addresses are 0 = direction, 1 = port data, 2 = pull-up control. Reads of addresses 0 and 2 return the register. Address 3 reads 0x00, and writes to it change nothing.
- R6: A read of address 1 returns the output data bit for pins whose direction bit is 1 and padIn for pins whose direction bit is 0. busRdData always equals padIn.
- R7: While porRstN is low, direction, output data and pull-up control are all 0x00.
- R8: A low level on manRstN clears direction and output data to 0x00 and leaves pull-up control unchanged.
- R9: At each clock edge with hwStandby high, pull-up control is cleared to 0x00, and register writes are ignored.
- R10: While swStandby is high, register writes are ignored and all three registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low |
| manRstN | input | 1 | Manual reset, asynchronous, active low |
| hwStandby | input | 1 | Hardware standby request |
| swStandby | input | 1 | Software standby request |
| mode | input | 3 | Operating mode |
| busWide | input | 1 | Bus width, 1 = 16-bit |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational |
| padIn | input | 8 | Sampled pin levels |
| padOut | output | 8 | Pin output values |
| padOe | output | 8 | Pin output enables |
| padPullUp | output | 8 | Pin pull-up enables |
| busWrData | input | 8 | Data from the bus controller to the pins |
| busDriveReq | input | 1 | Bus controller write strobe that enables the drivers |
| busRdData | output | 8 | Pin levels returned to the bus controller |

## Verification
The assertions check four properties on every cycle. A pin never has its output driver and its pull-up on together. In data-bus operation the drivers and outputs follow the bus controller and the pull-ups stay off. Hardware standby leaves the pull-ups off one edge later. Software standby freezes the pull-ups while the mode and bus-width inputs are steady. Other behaviour shows only in the bench's scenarios: the mode and bus-width sweep over several register patterns, the mixed read of the data address, and how each of the three register types reacts to manual reset, power-on reset and the two standby inputs.

// File: rtl/dualPortPkg.sv
package dualPortPkg;
  typedef struct packed {
    logic wrDir;
    logic wrOut;
    logic wrPu;
    logic clrPu;
    logic gpioMode;
    logic busDrive;
  } portCtl_t;

  localparam int ADDR_DIR  = 0;
  localparam int ADDR_DATA = 1;
  localparam int ADDR_PU   = 2;
  localparam int SC_MODE_A = 3;
  localparam int SC_MODE_B = 7;
endpackage

// File: rtl/portCtrl.sv
module portCtrl
  import dualPortPkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int MODE_W = 3
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              busWide,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic              busDriveReq,
  output portCtl_t          ctl
);
  logic wrAllowed;
  logic singleChip;

  assign wrAllowed  = regWrEn && !hwStandby && !swStandby;
  assign singleChip = (mode == MODE_W'(SC_MODE_A)) || (mode == MODE_W'(SC_MODE_B));

  always_comb begin
    ctl          = '0;
    ctl.wrDir    = wrAllowed && (regAddr == ADDR_W'(ADDR_DIR));
    ctl.wrOut    = wrAllowed && (regAddr == ADDR_W'(ADDR_DATA));
    ctl.wrPu     = wrAllowed && (regAddr == ADDR_W'(ADDR_PU));
    ctl.clrPu    = hwStandby;
    ctl.gpioMode = singleChip || !busWide;
    ctl.busDrive = !ctl.gpioMode && busDriveReq;
  end
endmodule

// File: rtl/portDatapath.sv
module portDatapath
  import dualPortPkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              manRstN,
  input  portCtl_t          ctl,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [W-1:0]      regWrData,
  input  logic [W-1:0]      padIn,
  input  logic [W-1:0]      busWrData,
  output logic [W-1:0]      padOut,
  output logic [W-1:0]      padOe,
  output logic [W-1:0]      padPullUp,
  output logic [W-1:0]      regRdData,
  output logic [W-1:0]      busRdData
);
  logic [W-1:0] dirReg;
  logic [W-1:0] outReg;
  logic [W-1:0] puReg;
  logic [W-1:0] pinView;

  always_ff @(posedge clk or negedge porRstN or negedge manRstN) begin
    if (!porRstN || !manRstN) begin
      dirReg <= '0;
      outReg <= '0;
    end else begin
      if (ctl.wrDir) dirReg <= regWrData;
      if (ctl.wrOut) outReg <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)       puReg <= '0;
    else if (ctl.clrPu) puReg <= '0;
    else if (ctl.wrPu)  puReg <= regWrData;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign padOe[i]     = ctl.gpioMode ? dirReg[i] : ctl.busDrive;
    assign padOut[i]    = ctl.gpioMode ? outReg[i] : busWrData[i];
    assign padPullUp[i] = ctl.gpioMode && !dirReg[i] && puReg[i];
    assign pinView[i]   = dirReg[i] ? outReg[i] : padIn[i];
  end

  assign busRdData = padIn;

  always_comb begin
    unique case (int'(regAddr))
      ADDR_DIR:  regRdData = dirReg;
      ADDR_DATA: regRdData = pinView;
      ADDR_PU:   regRdData = puReg;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/dual_use_port.sv
module dual_use_port
  import dualPortPkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 2,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              manRstN,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic [MODE_W-1:0] mode,
  input  logic              busWide,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [W-1:0]      regWrData,
  output logic [W-1:0]      regRdData,
  input  logic [W-1:0]      padIn,
  output logic [W-1:0]      padOut,
  output logic [W-1:0]      padOe,
  output logic [W-1:0]      padPullUp,
  input  logic [W-1:0]      busWrData,
  input  logic              busDriveReq,
  output logic [W-1:0]      busRdData
);
  portCtl_t ctl;

  portCtrl #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_ctrl (
    .mode(mode), .busWide(busWide), .regWrEn(regWrEn), .regAddr(regAddr),
    .hwStandby(hwStandby), .swStandby(swStandby), .busDriveReq(busDriveReq),
    .ctl(ctl)
  );

  portDatapath #(.W(W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .porRstN(porRstN), .manRstN(manRstN), .ctl(ctl),
    .regAddr(regAddr), .regWrData(regWrData), .padIn(padIn),
    .busWrData(busWrData), .padOut(padOut), .padOe(padOe),
    .padPullUp(padPullUp), .regRdData(regRdData), .busRdData(busRdData)
  );
endmodule

// File: rtl/portChk.sv
module portChk #(
  parameter int W      = 8,
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              porRstN,
  input logic              manRstN,
  input logic              hwStandby,
  input logic              swStandby,
  input logic [MODE_W-1:0] mode,
  input logic              busWide,
  input logic              busDriveReq,
  input logic [W-1:0]      busWrData,
  input logic [W-1:0]      padOut,
  input logic [W-1:0]      padOe,
  input logic [W-1:0]      padPullUp
);
  logic busMode;
  assign busMode = busWide && (mode != MODE_W'(3)) && (mode != MODE_W'(7));

  // R4
  pull_exclusive_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (padOe & padPullUp) == '0);

  // R3
  bus_drive_chk: assert property (@(posedge clk) disable iff (!porRstN)
    busMode |-> (padOe == {W{busDriveReq}}) && (padOut == busWrData));

  // R4
  bus_pull_chk: assert property (@(posedge clk) disable iff (!porRstN)
    busMode |-> padPullUp == '0);

  // R9
  hw_clear_chk: assert property (@(posedge clk) disable iff (!porRstN)
    hwStandby |=> padPullUp == '0);

  // R10
  sw_hold_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (swStandby && !hwStandby && manRstN) |=>
      (!$stable(mode) || !$stable(busWide) || !manRstN || $stable(padPullUp)));
endmodule

bind dual_use_port portChk #(.W(W), .MODE_W(MODE_W)) chk (
  .clk(clk), .porRstN(porRstN), .manRstN(manRstN), .hwStandby(hwStandby),
  .swStandby(swStandby), .mode(mode), .busWide(busWide),
  .busDriveReq(busDriveReq), .busWrData(busWrData), .padOut(padOut),
  .padOe(padOe), .padPullUp(padPullUp)
);

// File: tb/dual_use_port_test.sv
module dual_use_port_test;
  logic       clk = 1'b0;
  logic       porRstN = 1'b0, manRstN = 1'b1, hwStandby = 1'b0, swStandby = 1'b0;
  logic [2:0] mode = 3'd3;
  logic       busWide = 1'b0, regWrEn = 1'b0, busDriveReq = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0, padIn = '0, busWrData = '0;
  logic [7:0] regRdData, padOut, padOe, padPullUp, busRdData;
  int runCnt = 0, failCnt = 0;
  bit finished = 0;

  dual_use_port uut (.*);

  always #4 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, string req, logic [7:0] exp);
    @(negedge clk);
    regAddr = a; #1;
    check(req, regRdData, exp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failCnt++;
    runCnt++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    // R7: state under power-on reset
    #3;
    check("R7 oe", padOe, 8'h00);
    check("R7 pull", padPullUp, 8'h00);
    regAddr = 2'd2; #1; check("R7 pu", regRdData, 8'h00);
    regAddr = 2'd0; #1; check("R7 dir", regRdData, 8'h00);
    @(negedge clk); porRstN = 1'b1;

    // R5: address 3 reads zero and ignores writes
    wr(2'd3, 8'hFF);
    rd(2'd3, "R5 addr3", 8'h00);
    rd(2'd0, "R5 addr3 no dir", 8'h00);
    rd(2'd2, "R5 addr3 no pu", 8'h00);

    // R1 R2 R3 R4 R6: sweep of modes, widths and patterns
    foreach (pats[k]) begin
      logic [7:0] d, o, p;
      d = pats[k]; o = ~d ^ 8'h5A; p = 8'h96 ^ {d[3:0], d[7:4]};
      wr(2'd0, d); wr(2'd1, o); wr(2'd2, p);
      rd(2'd0, "R5 dir rb", d);
      rd(2'd2, "R5 pu rb", p);
      for (int m = 0; m < 8; m++) begin
        for (int bw = 0; bw < 2; bw++) begin
          logic gpio, drv;
          logic [7:0] pin;
          @(negedge clk);
          mode = 3'(m); busWide = bw[0];
          pin = 8'hC3 ^ d ^ 8'(m * 7);
          padIn = pin; busWrData = 8'(m * 17 + bw);
          drv = bw[0] ^ m[0]; busDriveReq = drv;
          regAddr = 2'd1;
          #1;
          gpio = (m == 3) || (m == 7) || (bw == 0);
          check(gpio ? "R1 R2 oe" : "R3 oe", padOe, gpio ? d : {8{drv}});
          check(gpio ? "R1 R2 out" : "R3 out", padOut, gpio ? o : busWrData);
          check("R4 pull", padPullUp, gpio ? (~d & p) : 8'h00);
          check("R6 read", regRdData, (d & o) | (~d & pin));
          check("R6 busRd", busRdData, pin);
        end
      end
    end

    // R8: manual reset
    @(negedge clk); mode = 3'd3; busWide = 1'b0; padIn = 8'h69;
    wr(2'd0, 8'h0F); wr(2'd1, 8'hFF); wr(2'd2, 8'hCC);
    @(negedge clk); manRstN = 1'b0;
    @(negedge clk); manRstN = 1'b1;
    rd(2'd0, "R8 dir", 8'h00);
    rd(2'd1, "R8 data", 8'h69);
    rd(2'd2, "R8 pu kept", 8'hCC);
    check("R8 pull", padPullUp, 8'hCC);
    wr(2'd0, 8'hFF);
    rd(2'd1, "R8 out cleared", 8'h00);

    // R10: software standby
    @(negedge clk); swStandby = 1'b1;
    wr(2'd0, 8'h00); wr(2'd2, 8'h11); wr(2'd1, 8'hAA);
    rd(2'd0, "R10 dir", 8'hFF);
    rd(2'd2, "R10 pu", 8'hCC);
    rd(2'd1, "R10 data", 8'h00);
    @(negedge clk); swStandby = 1'b0;
    wr(2'd0, 8'h30);
    check("R10 pull after", padPullUp, 8'hCC & 8'hCF);

    // R9: hardware standby
    @(negedge clk); hwStandby = 1'b1;
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'h00);
    rd(2'd2, "R9 pu", 8'h00);
    check("R9 pull", padPullUp, 8'h00);
    @(negedge clk); hwStandby = 1'b0;
    rd(2'd0, "R9 dir no write", 8'h30);

    // R7: power-on reset mid-run
    wr(2'd2, 8'h5A); wr(2'd1, 8'h77);
    @(negedge clk); porRstN = 1'b0; #1;
    regAddr = 2'd2; #1; check("R7 pu clr", regRdData, 8'h00);
    regAddr = 2'd0; #1; check("R7 dir clr", regRdData, 8'h00);
    @(negedge clk); porRstN = 1'b1;
    wr(2'd0, 8'hFF);
    rd(2'd1, "R7 out clr", 8'h00);

    summary();
  end
endmodule